// File: doc/BRIEF.md
# Store-to-Load Forwarding Search

This block keeps the in-flight stores of an ordered memory-operation window in an eight-slot circular queue. Each store gets a slot when it is allocated, in program order. Its address, access size and data are written into that slot when it executes. The oldest store leaves the queue through the commit port and drives the memory write signals in the same cycle.

A load presents its address, its size and its age. The age is the queue position of the first store that is younger than the load, with one extra wrap bit. The block searches all occupied, executed stores that are older than the load and whose bytes overlap the load's bytes.

The youngest of those stores decides the result:
- If it covers every byte the load reads, its data is forwarded, aligned to the load and zero-extended.
- If it covers only part of the load, the load is told to retry.
- If no older store overlaps, a memory read request is raised instead.

Ages are compared relative to the head pointer, so the search works across wrap-around.

Top module: `sq_fwd_search`

## Requirements
- R1: After reset the queue is empty: `q_full`, `alloc_tag`, `fw_hit`, `fw_retry`, `rd_req` and `mw_vld` are all 0.
- R2: An accepted allocation returns the tail position in `alloc_tag` (slot index in the low 3 bits, wrap bit on top), and the next allocation returns that value plus one, modulo 16. When eight stores are held, `q_full` is 1. Further allocations are ignored, and `alloc_tag` and `q_full` stay unchanged.
- R3: Load results appear in the cycle after `ld_vld`. Exactly one of `fw_hit`, `fw_retry` and `rd_req` is then 1. In every other cycle all three are 0, and so is `fw_data`.
- R4: When no executed, occupied store older than the load shares a byte with it, `rd_req` is 1 and `rd_addr` equals the load address.
- R5: Stores at or after the load's age, and stores that are allocated but not yet executed, take no part in the search. An execute in the same cycle as a query becomes visible from the next cycle on.
- R6: When several older stores overlap the load, only the youngest of them, the one nearest the load's age, decides the result.
- R7: Size codes are 0 = byte, 1 = half, 2 = word, with natural alignment inside a 4-byte word. When the deciding store covers every load byte, `fw_hit` is 1. `fw_data` then holds the load's bytes taken from the store, shifted down by the load's byte offset and zero-extended above the load size.
- R8: When the deciding store overlaps the load only in part, `fw_retry` is 1 and `fw_data` is 0.
- R9: While `cmt_vld` is 1 and the head slot is occupied and executed, `mw_vld` is 1 in the same cycle. `mw_addr` then carries the word-aligned address, `mw_be` the byte lanes (bit n for byte n), and `mw_data` the store bytes in those lanes with 0 elsewhere; the slot is freed at the clock edge. Otherwise the commit is ignored and the head stays where it is.
- R10: Ages and slot indices that wrap past slot 7 are ordered correctly relative to the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_vld | input | 1 | Request a slot for a new store |
| alloc_tag | output | 4 | Position the next allocation receives (wrap bit + slot) |
| q_full | output | 1 | All eight slots are occupied |
| exe_vld | input | 1 | A store has executed |
| exe_slot | input | 3 | Slot of the executed store |
| exe_addr | input | 32 | Byte address of the executed store |
| exe_size | input | 2 | Size code of the executed store |
| exe_data | input | 32 | Store value, right-aligned |
| cmt_vld | input | 1 | Commit the oldest store |
| mw_vld | output | 1 | Memory write strobe for the committed store |
| mw_addr | output | 32 | Word-aligned write address |
| mw_be | output | 4 | Byte lanes written |
| mw_data | output | 32 | Write data in byte lanes |
| ld_vld | input | 1 | Load search request |
| ld_addr | input | 32 | Load byte address |
| ld_size | input | 2 | Load size code |
| ld_age | input | 4 | Position of the first store younger than the load |
| fw_hit | output | 1 | Forwarded data is valid |
| fw_data | output | 32 | Forwarded load value, zero-extended |
| fw_retry | output | 1 | Partial overlap, the load must retry |
| rd_req | output | 1 | The load must read memory |
| rd_addr | output | 32 | Address of the memory read |

## Verification
The load outcome (`fw_hit`, `fw_data`, `fw_retry`, `rd_req`, `rd_addr`) comes from one register. The bench therefore raises `ld_vld` just after an edge and samples on the falling edge that follows the next rising edge.

The commit signals are combinational from the head slot. They are sampled a few nanoseconds after `cmt_vld` rises, before the edge that frees the slot.

Allocation and execute effects show up one edge later. `alloc_tag` and `q_full` are read after that edge, and no load query is issued in the cycle of an execute it depends on.

Loads sweep every aligned offset and size over four words and every legal age, before and after the queue wraps.

// File: rtl/sq_pkg.sv
`timescale 1ns/1ps
package sq_pkg;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;

   function automatic logic [3:0] lane_mask(input logic [1:0] off, input logic [1:0] sz);
      logic [3:0] m;
      case (sz)
         SZ_BYTE: m = 4'b0001 << off;
         SZ_HALF: m = off[1] ? 4'b1100 : 4'b0011;
         default: m = 4'b1111;
      endcase
      return m;
   endfunction

   function automatic logic [31:0] lane_bits(input logic [3:0] m);
      logic [31:0] b;
      for (int n = 0; n < 4; n++) b[n*8 +: 8] = {8{m[n]}};
      return b;
   endfunction

   function automatic logic [31:0] size_keep(input logic [1:0] sz);
      logic [31:0] k;
      case (sz)
         SZ_BYTE: k = 32'h0000_00FF;
         SZ_HALF: k = 32'h0000_FFFF;
         default: k = 32'hFFFF_FFFF;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/sq_ptrs.sv
`timescale 1ns/1ps
module sq_ptrs #(
   parameter int DEPTH = 8,
   localparam int PW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   output logic [PW:0]   head,
   output logic [PW:0]   tail,
   output logic [PW:0]   count,
   output logic          full
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head <= '0;
         tail <= '0;
      end else begin
         if (push) tail <= tail + 1'b1;
         if (pop)  head <= head + 1'b1;
      end
   end

   assign count = tail - head;
   assign full  = (count == (PW+1)'(DEPTH));

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count <= (PW+1)'(DEPTH)); // R2

endmodule

// File: rtl/sq_slot_array.sv
`timescale 1ns/1ps
module sq_slot_array
   import sq_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int AW    = 32,
   localparam int PW   = $clog2(DEPTH),
   localparam int WAW  = AW - 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc,
   input  logic [PW-1:0]    alloc_slot,
   input  logic             exe_vld,
   input  logic [PW-1:0]    exe_slot,
   input  logic [AW-1:0]    exe_addr,
   input  logic [1:0]       exe_size,
   input  logic [31:0]      exe_data,
   input  logic [AW-1:0]    ld_addr,
   input  logic [1:0]       ld_size,
   output logic [DEPTH-1:0] exe_done,
   output logic [DEPTH-1:0] ovl,
   output logic [DEPTH-1:0] cov,
   output logic [WAW-1:0]   word_q [DEPTH],
   output logic [3:0]       mask_q [DEPTH],
   output logic [31:0]      lane_q [DEPTH]
);

   logic [3:0]  ld_mask;
   logic [3:0]  exe_mask;
   logic [31:0] exe_lane;

   assign ld_mask  = lane_mask(ld_addr[1:0], ld_size);
   assign exe_mask = lane_mask(exe_addr[1:0], exe_size);
   assign exe_lane = (exe_data << {exe_addr[1:0], 3'b000}) & lane_bits(exe_mask);

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      localparam logic [PW-1:0] ID = PW'(i);
      logic wr_here;
      logic [3:0] common;

      assign wr_here = exe_vld && (exe_slot == ID);

      always_ff @(posedge clk) begin
         if (!rst_n)                          exe_done[i] <= 1'b0;
         else if (alloc && alloc_slot == ID)  exe_done[i] <= 1'b0;
         else if (wr_here)                    exe_done[i] <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            word_q[i] <= '0;
            mask_q[i] <= '0;
            lane_q[i] <= '0;
         end else if (wr_here) begin
            word_q[i] <= exe_addr[AW-1:2];
            mask_q[i] <= exe_mask;
            lane_q[i] <= exe_lane;
         end
      end

      assign common = mask_q[i] & ld_mask;
      assign ovl[i] = exe_done[i] && (word_q[i] == ld_addr[AW-1:2]) && (common != 4'b0000);
      assign cov[i] = (common == ld_mask);

      AST_ALLOC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (alloc && alloc_slot == ID) |=> !exe_done[i]); // R5
   end

endmodule

// File: rtl/sq_age_pick.sv
`timescale 1ns/1ps
module sq_age_pick #(
   parameter int DEPTH = 8,
   localparam int PW = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0] cand,
   input  logic [PW-1:0]    head,
   output logic             found,
   output logic [PW-1:0]    sel
);

   // Walk from oldest to youngest; the last candidate seen is the youngest.
   always_comb begin
      found = 1'b0;
      sel   = head;
      for (int k = 0; k < DEPTH; k++) begin
         logic [PW-1:0] idx;
         idx = head + k[PW-1:0];
         if (cand[idx]) begin
            found = 1'b1;
            sel   = idx;
         end
      end
   end

endmodule

// File: rtl/sq_fwd_search.sv
`timescale 1ns/1ps
module sq_fwd_search
   import sq_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int AW    = 32,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          alloc_vld,
   output logic [PW:0]   alloc_tag,
   output logic          q_full,
   input  logic          exe_vld,
   input  logic [PW-1:0] exe_slot,
   input  logic [AW-1:0] exe_addr,
   input  logic [1:0]    exe_size,
   input  logic [31:0]   exe_data,
   input  logic          cmt_vld,
   output logic          mw_vld,
   output logic [AW-1:0] mw_addr,
   output logic [3:0]    mw_be,
   output logic [31:0]   mw_data,
   input  logic          ld_vld,
   input  logic [AW-1:0] ld_addr,
   input  logic [1:0]    ld_size,
   input  logic [PW:0]   ld_age,
   output logic          fw_hit,
   output logic [31:0]   fw_data,
   output logic          fw_retry,
   output logic          rd_req,
   output logic [AW-1:0] rd_addr
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("sq_fwd_search: DEPTH must be a power of two of at least 2");
   end
   if (AW < 3) begin : g_bad_aw
      $error("sq_fwd_search: AW must be at least 3");
   end

   localparam int WAW = AW - 2;

   logic [PW:0]      head, tail, count;
   logic             push, pop;
   logic [DEPTH-1:0] exe_done, ovl, cov, older, cand;
   logic [WAW-1:0]   word_q [DEPTH];
   logic [3:0]       mask_q [DEPTH];
   logic [31:0]      lane_q [DEPTH];
   logic             found;
   logic [PW-1:0]    sel;
   logic [PW-1:0]    hslot;
   logic [PW:0]      ld_rel;

   assign push  = alloc_vld && !q_full;
   assign hslot = head[PW-1:0];
   assign pop   = cmt_vld && (count != '0) && exe_done[hslot];

   sq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
      .head(head), .tail(tail), .count(count), .full(q_full)
   );

   sq_slot_array #(.DEPTH(DEPTH), .AW(AW)) u_slots (
      .clk(clk), .rst_n(rst_n),
      .alloc(push), .alloc_slot(tail[PW-1:0]),
      .exe_vld(exe_vld), .exe_slot(exe_slot), .exe_addr(exe_addr),
      .exe_size(exe_size), .exe_data(exe_data),
      .ld_addr(ld_addr), .ld_size(ld_size),
      .exe_done(exe_done), .ovl(ovl), .cov(cov),
      .word_q(word_q), .mask_q(mask_q), .lane_q(lane_q)
   );

   // Relative age of each slot from the head; a slot is older than the load
   // when it is occupied and lies before the load's position.
   assign ld_rel = ld_age - head;
   for (genvar i = 0; i < DEPTH; i++) begin : g_age
      logic [PW:0] rel;
      assign rel      = {1'b0, PW'(i) - hslot};
      assign older[i] = (rel < count) && (rel < ld_rel);
   end
   assign cand = ovl & older;

   sq_age_pick #(.DEPTH(DEPTH)) u_pick (
      .cand(cand), .head(hslot), .found(found), .sel(sel)
   );

   logic        hit_n, retry_n, rd_n;
   logic [31:0] data_n;

   assign hit_n   = ld_vld && found && cov[sel];
   assign retry_n = ld_vld && found && !cov[sel];
   assign rd_n    = ld_vld && !found;
   assign data_n  = hit_n ? ((lane_q[sel] >> {ld_addr[1:0], 3'b000}) & size_keep(ld_size)) : 32'h0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fw_hit   <= 1'b0;
         fw_retry <= 1'b0;
         rd_req   <= 1'b0;
         fw_data  <= '0;
         rd_addr  <= '0;
      end else begin
         fw_hit   <= hit_n;
         fw_retry <= retry_n;
         rd_req   <= rd_n;
         fw_data  <= data_n;
         rd_addr  <= rd_n ? ld_addr : '0;
      end
   end

   assign alloc_tag = tail;
   assign mw_vld    = pop;
   assign mw_addr   = pop ? {word_q[hslot], 2'b00} : '0;
   assign mw_be     = pop ? mask_q[hslot] : 4'b0000;
   assign mw_data   = pop ? lane_q[hslot] : 32'h0;

   AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fw_hit, fw_retry, rd_req})); // R3
   AST_RESULT_NEEDS_QUERY: assert property (@(posedge clk) disable iff (!rst_n)
      (fw_hit || fw_retry || rd_req) |-> $past(ld_vld)); // R3
   AST_QUERY_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
      ld_vld |=> (fw_hit || fw_retry || rd_req)); // R3
   AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (fw_hit && $past(ld_size) == SZ_BYTE) |-> (fw_data[31:8] == 24'h0)); // R7
   AST_RETRY_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      fw_retry |-> (fw_data == 32'h0)); // R8
   AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      mw_vld |=> (head == $past(head) + 1'b1)); // R9
   AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (q_full && !mw_vld) |=> (q_full && $stable(alloc_tag))); // R2

endmodule

// File: tb/sim_sq_fwd_search.sv
`timescale 1ns/1ps
module sim_sq_fwd_search;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        alloc_vld = 1'b0;
   logic [3:0]  alloc_tag;
   logic        q_full;
   logic        exe_vld = 1'b0;
   logic [2:0]  exe_slot = '0;
   logic [31:0] exe_addr = '0;
   logic [1:0]  exe_size = '0;
   logic [31:0] exe_data = '0;
   logic        cmt_vld = 1'b0;
   logic        mw_vld;
   logic [31:0] mw_addr;
   logic [3:0]  mw_be;
   logic [31:0] mw_data;
   logic        ld_vld = 1'b0;
   logic [31:0] ld_addr = '0;
   logic [1:0]  ld_size = '0;
   logic [3:0]  ld_age = '0;
   logic        fw_hit;
   logic [31:0] fw_data;
   logic        fw_retry;
   logic        rd_req;
   logic [31:0] rd_addr;

   always #10 clk = ~clk;

   sq_fwd_search u0 (.*);

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   // Reference model of the queue
   int          mh = 0, mt = 0;
   logic [31:0] m_addr [8];
   int          m_size [8];
   logic [31:0] m_val  [8];
   bit          m_exe  [8];

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int nb(input int sz);
      return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
   endfunction

   task automatic do_alloc(input bit expect_ok);
      @(posedge clk); #1;
      alloc_vld = 1'b1;
      @(posedge clk); #1;
      alloc_vld = 1'b0;
      if (expect_ok) begin
         m_exe[mt & 7] = 1'b0;
         mt = (mt + 1) & 15;
      end
      check("R2 alloc_tag", {28'h0, alloc_tag}, mt[31:0]);
   endtask

   task automatic do_exe(input int slot, input logic [31:0] a, input int sz, input logic [31:0] v);
      @(posedge clk); #1;
      exe_vld = 1'b1; exe_slot = slot[2:0]; exe_addr = a; exe_size = sz[1:0]; exe_data = v;
      @(posedge clk); #1;
      exe_vld = 1'b0;
      m_addr[slot] = a; m_size[slot] = sz; m_val[slot] = v; m_exe[slot] = 1'b1;
   endtask

   task automatic do_load(input logic [31:0] a, input int sz, input int age);
      int lrel, best, lo, nl;
      bit e_hit, e_retry, e_rd;
      logic [31:0] e_data;
      longint mval;
      @(posedge clk); #1;
      ld_vld = 1'b1; ld_addr = a; ld_size = sz[1:0]; ld_age = age[3:0];
      @(posedge clk); #1;
      ld_vld = 1'b0;
      lrel = (age - mh) & 15;
      lo = a & 3; nl = nb(sz);
      best = -1;
      for (int k = 0; k < lrel; k++) begin
         int s, so, ns;
         s = (mh + k) & 7;
         so = m_addr[s] & 3; ns = nb(m_size[s]);
         if (m_exe[s] && (m_addr[s] >> 2) == (a >> 2) && so < lo + nl && lo < so + ns) best = s;
      end
      e_hit = 0; e_retry = 0; e_rd = 0; e_data = 0;
      if (best < 0) e_rd = 1;
      else begin
         int so, ns;
         so = m_addr[best] & 3; ns = nb(m_size[best]);
         if (so <= lo && lo + nl <= so + ns) begin
            e_hit = 1;
            mval = longint'(m_val[best]) >> (8 * (lo - so));
            mval = mval & ((64'd1 << (8 * nl)) - 1);
            e_data = mval[31:0];
         end else e_retry = 1;
      end
      @(negedge clk);
      if (e_rd) check("R4 rd_req", {31'h0, rd_req}, 32'h1);
      if (e_rd) check("R4 rd_addr", rd_addr, a);
      if (e_hit) check("R6 R7 fw_hit", {31'h0, fw_hit}, 32'h1);
      if (e_hit) check("R7 fw_data", fw_data, e_data);
      if (e_retry) check("R8 fw_retry", {31'h0, fw_retry}, 32'h1);
      if (e_retry) check("R8 fw_data", fw_data, 32'h0);
      check("R3 R5 outcome", {29'h0, fw_hit, fw_retry, rd_req}, {29'h0, e_hit, e_retry, e_rd});
   endtask

   task automatic sweep;
      int cnt;
      cnt = (mt - mh) & 15;
      for (int w = 0; w < 4; w++)
         for (int sz = 0; sz < 3; sz++)
            for (int off = 0; off < 4; off += nb(sz))
               for (int k = 0; k <= cnt; k++)
                  do_load(32'h100 + w * 4 + off, sz, (mh + k) & 15);
      @(negedge clk);
      check("R3 idle outputs", {28'h0, fw_hit, fw_retry, rd_req, |fw_data}, 32'h0);
   endtask

   task automatic do_commit(input bit expect_ok);
      int s;
      logic [3:0] e_be;
      logic [31:0] e_dat;
      s = mh & 7;
      @(posedge clk); #1;
      cmt_vld = 1'b1;
      #2;
      check("R9 mw_vld", {31'h0, mw_vld}, {31'h0, expect_ok});
      if (expect_ok) begin
         e_be = 0; e_dat = 0;
         for (int b = 0; b < 4; b++)
            if (b >= (m_addr[s] & 3) && b < (m_addr[s] & 3) + nb(m_size[s])) begin
               e_be[b] = 1'b1;
               e_dat[b*8 +: 8] = m_val[s][(b - (m_addr[s] & 3)) * 8 +: 8];
            end
         check("R9 mw_addr", mw_addr, m_addr[s] & 32'hFFFF_FFFC);
         check("R9 mw_be", {28'h0, mw_be}, {28'h0, e_be});
         check("R9 mw_data", mw_data, e_dat);
      end
      @(posedge clk); #1;
      cmt_vld = 1'b0;
      if (expect_ok) mh = (mh + 1) & 15;
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) begin m_addr[i] = 0; m_size[i] = 0; m_val[i] = 0; m_exe[i] = 0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1
      check("R1 reset outputs", {26'h0, q_full, fw_hit, fw_retry, rd_req, mw_vld, |alloc_tag}, 32'h0);

      for (int i = 0; i < 8; i++) do_alloc(1'b1);
      check("R2 full", {31'h0, q_full}, 32'h1);
      do_alloc(1'b0);
      check("R2 full kept", {31'h0, q_full}, 32'h1);

      // Load with nothing executed: all from memory (R5)
      do_load(32'h100, 2, 8);

      do_exe(0, 32'h100, 2, 32'h1122_3344);
      do_exe(3, 32'h104, 2, 32'h9988_7766);
      do_exe(1, 32'h102, 1, 32'hFFFF_AABB);
      do_exe(2, 32'h101, 0, 32'hFFFF_FF5C);
      do_exe(4, 32'h10A, 1, 32'h0000_1234);
      do_exe(6, 32'h105, 0, 32'h0000_00E1);
      do_exe(7, 32'h100, 0, 32'h0000_0007);
      // slot 5 stays unexecuted (R5)
      sweep();

      do_commit(1'b1); do_commit(1'b1); do_commit(1'b1);
      do_commit(1'b1); do_commit(1'b1);
      do_commit(1'b0);  // R9: head slot 5 not executed
      check("R2 not full after commits", {31'h0, q_full}, 32'h0);
      do_exe(5, 32'h108, 2, 32'hCAFE_F00D);
      do_commit(1'b1);

      // Wrap-around (R10): new stores land in slots 0..5
      for (int i = 0; i < 6; i++) do_alloc(1'b1);
      check("R10 R2 full after wrap", {31'h0, q_full}, 32'h1);
      do_exe(0, 32'h104, 1, 32'h0000_BEEF);
      do_exe(1, 32'h106, 0, 32'h0000_0042);
      do_exe(2, 32'h100, 2, 32'h0BAD_C0DE);
      do_exe(3, 32'h10C, 2, 32'h1357_9BDF);
      do_exe(5, 32'h102, 1, 32'h0000_7788);
      sweep();

      while (mh != mt) begin
         if (!m_exe[mh & 7]) do_exe(mh & 7, 32'h10E, 1, 32'h0000_5A5A);
         do_commit(1'b1);
      end
      @(negedge clk);
      check("R9 drained", {30'h0, q_full, mw_vld}, 32'h0);
      sweep();

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule